// File: doc/BRIEF.md
# I2C Master SCL Pacer

This block paces the clock line of an I2C master from the system clock. A programmable even divider sets the length of one bit slot. In each slot the block pulls SCL low for half the slot and releases it for the other half. It also gives the byte engine that sits beside it three timing marks: a bit-slot tick, an SDA update strobe and an SDA sample strobe. The update strobe lands a programmable number of core clocks after SCL is pulled low. The sample strobe lands a programmable number of core clocks after SCL is first seen high. Each of these two delays is clamped so that it stays inside its half-slot.

After SCL is released, the high half does not start until the line is actually sensed high. A slave that holds SCL low therefore stretches the slot. While SCL is held low, the block counts elapsed nominal slot periods. When the count reaches a programmable limit, it pulses a timeout and parks with SCL released until the enable is withdrawn.

The controlling state machine has five states:
- IDLE: SCL is released and the block waits for enable.
- LOW: SCL is pulled low.
- RELEASE: SCL is released and the block waits for the line to read high; the stretch watch runs here.
- HIGH: the remaining high-phase cycles are counted.
- FAULT: entered after a timeout; SCL is released.

The transitions are:
- IDLE→LOW when enable is high.
- LOW→RELEASE after half a slot.
- RELEASE→HIGH when SCL is sensed high.
- RELEASE→LOW or RELEASE→IDLE when SCL is sensed high and the half-slot is a single cycle.
- RELEASE→FAULT on timeout.
- HIGH→LOW at the end of the slot if enable is high, HIGH→IDLE otherwise.
- FAULT→IDLE once enable is low.

Top module: `scl_pacer`

## Requirements
- R1: After reset, and for as long as `run_en` stays low in idle, `scl_drive_low`, `slot_tick`, `sda_upd_stb`, `sda_smp_stb` and `stretch_tmo` are all 0.
- R2: The slot length D is `div_cfg` with bit 0 forced to 0. With no stretching, SCL is driven low (`scl_drive_low`=1) for exactly D/2 cycles. It is then released for exactly D/2 cycles, so one slot lasts D core clocks. The first low cycle is the cycle after the clock edge that sees `run_en` high in idle.
- R3: A value of `div_cfg` that becomes 0 after bit 0 is cleared (0 or 1) selects D = 32768.
- R4: `slot_tick` is high for exactly the first cycle of each low phase and at no other time.
- R5: `sda_upd_stb` is high for exactly one cycle per low phase, in low-phase cycle F (counting from 0). The raw value F is `edge_dly_cfg[31:16]`.
- R6: `sda_smp_stb` is high for exactly one cycle per high phase, in cycle R of that phase. Counting starts at 0 on the first cycle SCL is sensed high after release. The raw value R is `edge_dly_cfg[15:0]`.
- R7: The F and R actually used are each min(raw value, D/2 − 1).
- R8: While SCL is released but sensed low, no high-phase cycle is counted. The high phase lasts D/2 cycles from the first cycle sensed high, so a stretch of S cycles lengthens the slot by S.
- R9: With `stretch_lim` = L ≠ 0, `stretch_tmo` pulses for one cycle in released-low cycle L·D (counting from 1). After the pulse, SCL stays released and no tick or strobe is produced, even after the line goes high. This lasts until `run_en` is seen low; `run_en` high then starts a new slot.
- R10: With `stretch_lim` = 0, `stretch_tmo` never fires however long SCL is held low.
- R11: When `run_en` is low at the end of a high phase, the block returns to idle with SCL released. A slot already in progress when `run_en` drops still completes both of its halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Keep generating bit slots while high |
| scl_sense | input | 1 | Sensed level of the SCL line (already synchronised) |
| div_cfg | input | 16 | Slot length in core clocks; bit 0 ignored, 0 means 32768 |
| edge_dly_cfg | input | 32 | [31:16] delay to SDA update after SCL low, [15:0] delay to SDA sample after SCL high |
| stretch_lim | input | 16 | Stretch timeout in nominal slot periods; 0 disables |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| slot_tick | output | 1 | One-cycle mark at the start of each bit slot |
| sda_upd_stb | output | 1 | One-cycle strobe: change SDA now |
| sda_smp_stb | output | 1 | One-cycle strobe: sample SDA now |
| stretch_tmo | output | 1 | One-cycle pulse when the stretch limit is reached |

## Verification
The bench sweeps every small divider, odd and even, against every update and sample delay up to and beyond the half-slot. This exposes a design that ignores the forced-even rule, fails to clamp and so loses a strobe, or counts the first sensed-high cycle twice and drifts the period by one. The zero and one divider settings are each run through a full slot, which catches a design that takes 0 literally and so stalls or runs a one-cycle slot. Stretch cases hold SCL low across several nominal periods with a zero limit and with a limit not yet reached. These show whether a design times out when it should not, or starts its high count before the line rises. Timeout cases at limits of one to three check that the pulse lands in the exact cycle and that the block stays parked until the enable drops. An off-by-one period counter would fire a cycle early or late, and a design that resumes on its own would drive SCL low again.

// File: rtl/scl_pacer_pkg.sv
`timescale 1ns/1ps
package scl_pacer_pkg;

    // Phases of one bit slot plus the parked states.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_LOW     = 3'd1,
        PH_RELEASE = 3'd2,
        PH_HIGH    = 3'd3,
        PH_FAULT   = 3'd4
    } phase_e;

endpackage

// File: rtl/scl_pacer_cfg.sv
`timescale 1ns/1ps
// Turns the raw settings into the slot length, the last half-slot index
// and the two clamped edge delays.
module scl_pacer_cfg #(
    parameter int DIV_W = 16,
    parameter int DLY_W = 16
) (
    input  logic [DIV_W-1:0]   div_cfg,
    input  logic [2*DLY_W-1:0] edge_dly_cfg,
    output logic [DIV_W-1:0]   period,
    output logic [DIV_W-1:0]   half_m1,
    output logic [DIV_W-1:0]   fall_eff,
    output logic [DIV_W-1:0]   rise_eff
);
    localparam int CMP_W = (DIV_W > DLY_W) ? DIV_W : DLY_W;
    localparam logic [DIV_W-1:0] EVEN_MASK = {{(DIV_W-1){1'b1}}, 1'b0};
    localparam logic [DIV_W-1:0] ZERO_DIV  = {1'b1, {(DIV_W-1){1'b0}}};

    logic [DIV_W-1:0] div_even;
    logic [DLY_W-1:0] raw_dly [2];
    logic [DIV_W-1:0] eff_dly [2];

    always_comb begin
        div_even = div_cfg & EVEN_MASK;
        period   = (div_even == '0) ? ZERO_DIV : div_even;
        half_m1  = (period >> 1) - DIV_W'(1);
    end

    assign raw_dly[0] = edge_dly_cfg[2*DLY_W-1:DLY_W];
    assign raw_dly[1] = edge_dly_cfg[DLY_W-1:0];

    // Same saturating clamp for both delays.
    for (genvar g = 0; g < 2; g++) begin : g_clamp
        logic [CMP_W-1:0] raw_x;
        logic [CMP_W-1:0] cap_x;
        always_comb begin
            raw_x      = CMP_W'(raw_dly[g]);
            cap_x      = CMP_W'(half_m1);
            eff_dly[g] = (raw_x > cap_x) ? half_m1 : DIV_W'(raw_dly[g]);
        end
    end

    assign fall_eff = eff_dly[0];
    assign rise_eff = eff_dly[1];

endmodule

// File: rtl/scl_pacer_stretch.sv
`timescale 1ns/1ps
// Counts nominal slot periods while SCL is released but held low and
// flags the cycle in which the programmed limit is reached.
module scl_pacer_stretch #(
    parameter int DIV_W = 16,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             watching,
    input  logic [DIV_W-1:0] period,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [DIV_W-1:0] per_cnt;
    logic [TMO_W-1:0] slot_cnt;
    logic             period_end;

    always_comb begin
        period_end = (per_cnt == period - DIV_W'(1));
        expire     = watching && (limit != '0) && period_end &&
                     (slot_cnt == limit - TMO_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_cnt  <= '0;
            slot_cnt <= '0;
        end else if (!watching) begin
            per_cnt  <= '0;
            slot_cnt <= '0;
        end else if (period_end) begin
            per_cnt  <= '0;
            slot_cnt <= slot_cnt + TMO_W'(1);
        end else begin
            per_cnt  <= per_cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/scl_pacer_seq.sv
`timescale 1ns/1ps
// Slot state machine: phase register, next-phase logic, output decode.
module scl_pacer_seq
    import scl_pacer_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             scl_sense,
    input  logic [DIV_W-1:0] half_m1,
    input  logic [DIV_W-1:0] fall_eff,
    input  logic [DIV_W-1:0] rise_eff,
    input  logic             expire,
    output logic             drive_low,
    output logic             tick,
    output logic             upd_stb,
    output logic             smp_stb,
    output logic             watching
);
    phase_e           phase, phase_nx;
    logic [DIV_W-1:0] cnt, cnt_nx;

    // Phase and counter register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= phase_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next phase.
    always_comb begin
        phase_nx = phase;
        cnt_nx   = cnt;
        unique case (phase)
            PH_IDLE: begin
                if (run_en) begin
                    phase_nx = PH_LOW;
                    cnt_nx   = '0;
                end
            end
            PH_LOW: begin
                if (cnt == half_m1) begin
                    phase_nx = PH_RELEASE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + DIV_W'(1);
                end
            end
            PH_RELEASE: begin
                if (expire) begin
                    phase_nx = PH_FAULT;
                end else if (scl_sense) begin
                    // This cycle is high-phase cycle 0.
                    if (half_m1 == '0) begin
                        phase_nx = run_en ? PH_LOW : PH_IDLE;
                        cnt_nx   = '0;
                    end else begin
                        phase_nx = PH_HIGH;
                        cnt_nx   = DIV_W'(1);
                    end
                end
            end
            PH_HIGH: begin
                if (cnt == half_m1) begin
                    phase_nx = run_en ? PH_LOW : PH_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + DIV_W'(1);
                end
            end
            PH_FAULT: begin
                if (!run_en) begin
                    phase_nx = PH_IDLE;
                end
            end
            default: begin
                phase_nx = PH_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        drive_low = (phase == PH_LOW);
        tick      = (phase == PH_LOW) && (cnt == '0);
        upd_stb   = (phase == PH_LOW) && (cnt == fall_eff);
        smp_stb   = ((phase == PH_RELEASE) && scl_sense && (rise_eff == '0)) ||
                    ((phase == PH_HIGH) && (cnt == rise_eff));
        watching  = (phase == PH_RELEASE) && !scl_sense;
    end

endmodule

// File: rtl/scl_pacer.sv
`timescale 1ns/1ps
// I2C master SCL pacer: slot timing, edge strobes and stretch timeout.
module scl_pacer #(
    parameter int DIV_W = 16,
    parameter int DLY_W = 16,
    parameter int TMO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               scl_sense,
    input  logic [DIV_W-1:0]   div_cfg,
    input  logic [2*DLY_W-1:0] edge_dly_cfg,
    input  logic [TMO_W-1:0]   stretch_lim,
    output logic               scl_drive_low,
    output logic               slot_tick,
    output logic               sda_upd_stb,
    output logic               sda_smp_stb,
    output logic               stretch_tmo
);
    logic [DIV_W-1:0] period;
    logic [DIV_W-1:0] half_m1;
    logic [DIV_W-1:0] fall_eff;
    logic [DIV_W-1:0] rise_eff;
    logic             watching;
    logic             expire;

    scl_pacer_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_cfg (
        .div_cfg      (div_cfg),
        .edge_dly_cfg (edge_dly_cfg),
        .period       (period),
        .half_m1      (half_m1),
        .fall_eff     (fall_eff),
        .rise_eff     (rise_eff)
    );

    scl_pacer_stretch #(.DIV_W(DIV_W), .TMO_W(TMO_W)) u_stretch (
        .clk      (clk),
        .rst_n    (rst_n),
        .watching (watching),
        .period   (period),
        .limit    (stretch_lim),
        .expire   (expire)
    );

    scl_pacer_seq #(.DIV_W(DIV_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .scl_sense (scl_sense),
        .half_m1   (half_m1),
        .fall_eff  (fall_eff),
        .rise_eff  (rise_eff),
        .expire    (expire),
        .drive_low (scl_drive_low),
        .tick      (slot_tick),
        .upd_stb   (sda_upd_stb),
        .smp_stb   (sda_smp_stb),
        .watching  (watching)
    );

    assign stretch_tmo = expire;

endmodule

// File: rtl/scl_pacer_chk.sv
`timescale 1ns/1ps
module scl_pacer_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_sense,
    input logic scl_drive_low,
    input logic slot_tick,
    input logic sda_upd_stb,
    input logic sda_smp_stb,
    input logic stretch_tmo
);
    // R4: tick only while SCL is pulled low
    a_r4_tick_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |-> scl_drive_low);

    // R2: every low phase opens with a slot tick
    a_r2_low_opens_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> slot_tick);

    // R5: update strobe only inside the low phase
    a_r5_update_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        sda_upd_stb |-> scl_drive_low);

    // R6: sample strobe only while released and sensed high
    a_r6_sample_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        sda_smp_stb |-> (!scl_drive_low && scl_sense));

    // R9: timeout only while released and held low
    a_r9_tmo_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_tmo |-> (!scl_drive_low && !scl_sense));

    // R9: after the pulse SCL stays released and the pulse is single
    a_r9_parked_after_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_tmo |=> (!scl_drive_low && !stretch_tmo));

endmodule

bind scl_pacer scl_pacer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_sense     (scl_sense),
    .scl_drive_low (scl_drive_low),
    .slot_tick     (slot_tick),
    .sda_upd_stb   (sda_upd_stb),
    .sda_smp_stb   (sda_smp_stb),
    .stretch_tmo   (stretch_tmo)
);

// File: tb/scl_pacer_bench.sv
`timescale 1ns/1ps
module scl_pacer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        slave_hold = 1'b0;
    logic        scl_sense;
    logic [15:0] div_cfg = 16'd8;
    logic [31:0] edge_dly_cfg = 32'd0;
    logic [15:0] stretch_lim = 16'd0;
    logic        scl_drive_low, slot_tick, sda_upd_stb, sda_smp_stb, stretch_tmo;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    // Open-drain line: low if the master pulls or the slave holds.
    assign scl_sense = !scl_drive_low && !slave_hold;

    scl_pacer u_scl_pacer (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en        (run_en),
        .scl_sense     (scl_sense),
        .div_cfg       (div_cfg),
        .edge_dly_cfg  (edge_dly_cfg),
        .stretch_lim   (stretch_lim),
        .scl_drive_low (scl_drive_low),
        .slot_tick     (slot_tick),
        .sda_upd_stb   (sda_upd_stb),
        .sda_smp_stb   (sda_smp_stb),
        .stretch_tmo   (stretch_tmo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_div(input int raw);
        int d;
        d = raw & 16'hFFFE;
        if (d == 0) d = 32768;
        return d;
    endfunction

    function automatic int clamp(input int raw, input int h);
        return (raw > h - 1) ? h - 1 : raw;
    endfunction

    // Free-running slots without stretching (R2..R7, R11).
    task automatic sweep_case(input int div_raw, input int fe_raw, input int re_raw,
                              input int nbits, input string tag);
        int d, h, fe, re, last, ph;
        int nl, nt, nu, ns, ni;
        bit act;
        d = eff_div(div_raw);
        h = d / 2;
        fe = clamp(fe_raw, h);
        re = clamp(re_raw, h);
        nl = 0; nt = 0; nu = 0; ns = 0; ni = 0;
        @(negedge clk);
        div_cfg      = div_raw[15:0];
        edge_dly_cfg = {fe_raw[15:0], re_raw[15:0]};
        stretch_lim  = 16'd0;
        run_en       = 1'b1;
        last = nbits * d;
        for (int t = 0; t < last + 3; t++) begin
            @(negedge clk);
            if (t == last - 1) run_en = 1'b0;
            #1;
            ph  = t % d;
            act = (t < last);
            if (act) begin
                if (scl_drive_low !== (ph < h))      nl++;
                if (slot_tick     !== (ph == 0))     nt++;
                if (sda_upd_stb   !== (ph == fe))    nu++;
                if (sda_smp_stb   !== (ph == h + re)) ns++;
                if (stretch_tmo   !== 1'b0)          ni++;
            end else begin
                if ({scl_drive_low, slot_tick, sda_upd_stb, sda_smp_stb, stretch_tmo} !== 5'b0)
                    ni++;
            end
        end
        check(nl == 0, {"R2 low/high split ", tag}, nl, 0);
        check(nt == 0, {"R4 slot tick ", tag}, nt, 0);
        check(nu == 0, {"R5 R7 update strobe ", tag}, nu, 0);
        check(ns == 0, {"R6 R7 sample strobe ", tag}, ns, 0);
        check(ni == 0, {"R11 idle after run_en low ", tag}, ni, 0);
    endtask

    // One slot with the slave holding SCL for s cycles after release (R8, R10, R11).
    task automatic stretch_case(input int s, input int lim);
        int d, h, fe, re, b2, stop;
        int nl, nt, nu, ns, nm;
        d = 8; h = 4; fe = 1; re = 2;
        nl = 0; nt = 0; nu = 0; ns = 0; nm = 0;
        @(negedge clk);
        div_cfg      = 16'd8;
        edge_dly_cfg = {16'd1, 16'd2};
        stretch_lim  = lim[15:0];
        run_en       = 1'b1;
        b2   = d + s;
        stop = b2 + d;
        for (int t = 0; t < stop + 3; t++) begin
            @(negedge clk);
            if (t == h) slave_hold = 1'b1;
            if (t == h + s) slave_hold = 1'b0;
            if (t == b2) run_en = 1'b0;
            #1;
            if (scl_drive_low !== ((t < h) || (t >= b2 && t < b2 + h))) nl++;
            if (slot_tick     !== ((t == 0) || (t == b2)))             nt++;
            if (sda_upd_stb   !== ((t == fe) || (t == b2 + fe)))       nu++;
            if (sda_smp_stb   !== ((t == h + s + re) || (t == b2 + h + re))) ns++;
            if (stretch_tmo   !== 1'b0)                                nm++;
        end
        check(nl == 0, "R8 R11 low phase waits for line high", nl, 0);
        check(nt == 0, "R4 tick under stretch", nt, 0);
        check(nu == 0, "R5 update under stretch", nu, 0);
        check(ns == 0, "R8 R6 sample counted from sensed high", ns, 0);
        if (lim == 0) check(nm == 0, "R10 no timeout with limit 0", nm, 0);
        else          check(nm == 0, "R9 no timeout before limit", nm, 0);
    endtask

    // Slave holds SCL until past the limit (R9).
    task automatic tmo_case(input int div_raw, input int lim);
        int d, h, tt, rel, stop;
        int nm, nq;
        d = eff_div(div_raw);
        h = d / 2;
        nm = 0; nq = 0;
        @(negedge clk);
        div_cfg      = div_raw[15:0];
        edge_dly_cfg = 32'd0;
        stretch_lim  = lim[15:0];
        run_en       = 1'b1;
        tt   = h + lim * d - 1;
        rel  = tt + 6;
        stop = tt + 10;
        for (int t = 0; t <= stop; t++) begin
            @(negedge clk);
            if (t == h) slave_hold = 1'b1;
            if (t == rel) slave_hold = 1'b0;
            #1;
            if (stretch_tmo !== (t == tt)) nm++;
            if (scl_drive_low !== (t < h)) nq++;
            if (slot_tick !== (t == 0)) nq++;
            if (sda_upd_stb !== (t == 0)) nq++;
            if (sda_smp_stb !== 1'b0) nq++;
        end
        check(nm == 0, "R9 timeout pulse cycle", nm, 0);
        check(nq == 0, "R9 parked after timeout", nq, 0);
        @(negedge clk); run_en = 1'b0;
        @(negedge clk); run_en = 1'b1;
        @(negedge clk); #1;
        check(scl_drive_low === 1'b1 && slot_tick === 1'b1, "R9 restart after run_en low",
              {30'd0, scl_drive_low, slot_tick}, 3);
        run_en = 1'b0;
        repeat (d + 3) @(negedge clk);
    endtask

    initial begin
        int bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check({scl_drive_low, slot_tick, sda_upd_stb, sda_smp_stb, stretch_tmo} === 5'b0,
              "R1 outputs in reset", {27'd0, scl_drive_low, slot_tick, sda_upd_stb,
              sda_smp_stb, stretch_tmo}, 0);
        rst_n = 1'b1;
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            if ({scl_drive_low, slot_tick, sda_upd_stb, sda_smp_stb, stretch_tmo} !== 5'b0)
                bad++;
        end
        check(bad == 0, "R1 idle while run_en low", bad, 0);

        // R2 R4 R5 R6 R7: sweep of small dividers and all delays, incl. clamped ones
        for (int dr = 2; dr <= 13; dr++) begin
            int h;
            h = (dr & 16'hFFFE) / 2;
            for (int fi = 0; fi <= h + 1; fi++) begin
                for (int ri = 0; ri <= h + 1; ri++) begin
                    sweep_case(dr, (fi == h + 1) ? 16'hFFFF : fi,
                               (ri == h + 1) ? 16'hFFFF : ri, 2, "");
                end
            end
        end

        // R3: zero and one both mean 32768
        sweep_case(0, 3, 5, 1, "R3 div=0");
        sweep_case(1, 100, 20000, 1, "R3 div=1");

        // R8 R10: stretching without timeout
        stretch_case(3, 0);
        stretch_case(20, 4);
        stretch_case(40, 0);

        // R9: timeout at several limits
        tmo_case(4, 3);
        tmo_case(6, 1);
        tmo_case(8, 2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule